// File: doc/BRIEF.md
# AUX Request Sequencer with Defer Retry

This block carries out one auxiliary-channel request on behalf of a host. The host presents a 4-bit command, a 20-bit address, a byte count between 1 and 16 and, for writes, up to 16 payload bytes, and pulses `req_valid`. The sequencer then claims the channel and polls for a ready indication. It loads the outgoing payload and fires the request at a simplified link interface. It repeats the request while the far end answers with a defer reply. It then releases the channel and reports the outcome with a one-cycle `done` pulse.

The link side is a plain handshake. A trigger pulse starts an attempt, and a pending flag stays high while the attempt is in flight. When the attempt ends, the link presents a reply code, a received byte count and up to 16 received bytes. All waits come from one down-counter. One microsecond is `US_TICKS` clock cycles, so the same RTL runs with real delays in silicon and with short delays in simulation.

The host must hold `req_wdata` stable from the `req_valid` pulse until `done`. Command, address and byte count are captured at the start.

Top module: `aux_xact_seq`

## Requirements
- R1: After reset, `busy`, `done`, `own_req` and `link_trig` are all low.
- R2: Command bit 0 selects a read (1) or a write (0). For a write, `link_payload` is loaded from `req_wdata`, with byte i at bits 8i+7..8i. For a read, `link_payload` keeps its previous contents. In both cases `link_len` is the byte count minus one, and `link_cmd`/`link_addr` carry the request's command and address.
- R3: `own_req` rises in the cycle after `req_valid` is accepted. If `own_ack` is low in that cycle, the request ends with status IO_ERR (2) and no trigger is issued.
- R4: `chan_ready` is sampled at most `POLL_TRIES` times, with `POLL_US` microseconds of wait after each failed sample. If it is never seen high, the request ends with status BUSY (1) and no trigger is issued.
- R5: Each attempt is a single-cycle `link_trig`. The sequencer waits for `link_pending` to read low, then waits `SETTLE_US` microseconds and samples the reply. After a defer reply, the next trigger comes exactly `SETTLE_US*US_TICKS + 2` cycles after the first cycle in which pending reads low.
- R6: A reply code of DEFER (2) causes another attempt. After `MAX_TRIES` deferred attempts, the request ends with status REMOTE_ERR (3) and reply DEFER. No transaction issues more than `MAX_TRIES` triggers.
- R7: On a read, a received count different from the requested count gives REMOTE_ERR. Otherwise `rd_data` holds the received bytes in order (byte i at bits 8i+7..8i), and bytes at or beyond the count are zero.
- R8: Every exit path drops `own_req` and then checks that `own_ack` has fallen; if it has not, the status becomes IO_ERR. `done` follows exactly `1 + GUARD_US*US_TICKS` cycles during which the sequencer is busy and `own_req` is low.
- R9: `done` is a one-cycle pulse with `busy` low. With it come `done_status` (OK=0, BUSY=1, IO_ERR=2, REMOTE_ERR=3) and the last raw reply code in `done_reply` (ACK=0, NACK=1, DEFER=2). A non-defer reply such as NACK completes with status OK and passes the code through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start pulse, accepted while idle |
| req_cmd | input | 4 | Request command; bit 0 = read |
| req_addr | input | 20 | Request address |
| req_nbytes | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write bytes, held until done |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | Final status code |
| done_reply | output | 2 | Last raw reply code |
| rd_data | output | 128 | Read bytes, zero beyond count |
| own_req | output | 1 | Channel ownership request |
| own_ack | input | 1 | Ownership acknowledge |
| chan_ready | input | 1 | Channel ready indication |
| link_trig | output | 1 | Attempt trigger pulse |
| link_cmd | output | 4 | Command toward the link |
| link_addr | output | 20 | Address toward the link |
| link_len | output | 4 | Byte count minus one |
| link_payload | output | 128 | Outgoing payload words |
| link_pending | input | 1 | Attempt in flight |
| link_reply | input | 2 | Reply code of the finished attempt |
| link_rx_count | input | 5 | Received byte count |
| link_rx_data | input | 128 | Received bytes |

## Verification
Some rules hold on every cycle, and the assertions check those. A trigger is only ever issued while ownership is both requested and acknowledged, and never while an attempt is pending. Ownership is dropped whenever the sequencer is idle. `done` is a lone pulse outside the busy window. A transaction never issues more than `MAX_TRIES` triggers. The scenarios cover what only a complete request can show: exact spacing of retries and ready polls, defer exhaustion, count mismatch, an ownership refusal, an acknowledge stuck after release, payload retention across a read, and the byte order of returned data.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [1:0] {
    XS_OK         = 2'd0,
    XS_BUSY       = 2'd1,
    XS_IO_ERR     = 2'd2,
    XS_REMOTE_ERR = 2'd3
  } xact_status_e;

  localparam logic [1:0] RP_ACK   = 2'd0;
  localparam logic [1:0] RP_NACK  = 2'd1;
  localparam logic [1:0] RP_DEFER = 2'd2;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CLAIM, SQ_POLL, SQ_POLL_WAIT, SQ_LOAD, SQ_FIRE,
    SQ_PEND, SQ_SETTLE, SQ_EVAL, SQ_RELEASE, SQ_GUARD
  } seq_state_e;

endpackage

// File: rtl/aux_delay_timer.sv
module aux_delay_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)              cnt_n = load_val;
    else if (cnt_q != '0)  cnt_n = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/aux_payload_reg.sv
module aux_payload_reg #(
  parameter int NBYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dout <= '0;
    else if (en) dout <= din;
  end
endmodule

// File: rtl/aux_byte_mask.sv
module aux_byte_mask #(
  parameter int NBYTES = 16,
  parameter int CW     = 5
) (
  input  logic [8*NBYTES-1:0] din,
  input  logic [CW-1:0]       count,
  output logic [8*NBYTES-1:0] dout
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign dout[8*i +: 8] = (CW'(i) < count) ? din[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
  import aux_seq_pkg::*;
#(
  parameter int MAX_BYTES  = 16,
  parameter int ADDR_W     = 20,
  parameter int CMD_W      = 4,
  parameter int US_TICKS   = 125,
  parameter int POLL_US    = 100,
  parameter int POLL_TRIES = 3,
  parameter int SETTLE_US  = 400,
  parameter int GUARD_US   = 400,
  parameter int MAX_TRIES  = 16,
  localparam int DATA_W    = 8*MAX_BYTES,
  localparam int CNT_W     = $clog2(MAX_BYTES+1),
  localparam int LEN_W     = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_nbytes,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        done_status,
  output logic [1:0]        done_reply,
  output logic [DATA_W-1:0] rd_data,
  output logic              own_req,
  input  logic              own_ack,
  input  logic              chan_ready,
  output logic              link_trig,
  output logic [CMD_W-1:0]  link_cmd,
  output logic [ADDR_W-1:0] link_addr,
  output logic [LEN_W-1:0]  link_len,
  output logic [DATA_W-1:0] link_payload,
  input  logic              link_pending,
  input  logic [1:0]        link_reply,
  input  logic [CNT_W-1:0]  link_rx_count,
  input  logic [DATA_W-1:0] link_rx_data
);
  localparam int POLL_CYC   = POLL_US   * US_TICKS;
  localparam int SETTLE_CYC = SETTLE_US * US_TICKS;
  localparam int GUARD_CYC  = GUARD_US  * US_TICKS;
  localparam int LONG_AB    = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
  localparam int LONGEST    = (LONG_AB > GUARD_CYC) ? LONG_AB : GUARD_CYC;
  localparam int TW         = $clog2(LONGEST+1);
  localparam int PW         = $clog2(POLL_TRIES+1);
  localparam int RW         = $clog2(MAX_TRIES+1);
  localparam logic [TW-1:0] POLL_LD   = TW'(POLL_CYC-1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC-1);
  localparam logic [TW-1:0] GUARD_LD  = TW'(GUARD_CYC-1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_TRIES-1);
  localparam logic [RW-1:0] TRY_LAST  = RW'(MAX_TRIES-1);

  seq_state_e        state_q, state_n;
  logic [CMD_W-1:0]  cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  nb_q, nb_n;
  logic [PW-1:0]     poll_q, poll_n;
  logic [RW-1:0]     try_q, try_n;
  logic              own_q, own_n;
  xact_status_e      stat_q, stat_n;
  logic [1:0]        reply_q, reply_n;
  logic              done_q, done_n;
  logic              tmr_load, tmr_exp, pay_load, rd_cap;
  logic [TW-1:0]     tmr_val;
  logic [DATA_W-1:0] rx_masked;

  aux_delay_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  aux_payload_reg #(.NBYTES(MAX_BYTES)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .en(pay_load), .din(req_wdata), .dout(link_payload)
  );

  aux_byte_mask #(.NBYTES(MAX_BYTES), .CW(CNT_W)) u_rxmask (
    .din(link_rx_data), .count(nb_q), .dout(rx_masked)
  );

  always_comb begin
    state_n  = state_q;
    cmd_n    = cmd_q;
    addr_n   = addr_q;
    nb_n     = nb_q;
    poll_n   = poll_q;
    try_n    = try_q;
    own_n    = own_q;
    stat_n   = stat_q;
    reply_n  = reply_q;
    done_n   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    pay_load = 1'b0;
    rd_cap   = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (req_valid) begin
        cmd_n   = req_cmd;
        addr_n  = req_addr;
        nb_n    = req_nbytes;
        own_n   = 1'b1;
        stat_n  = XS_OK;
        reply_n = RP_ACK;
        poll_n  = '0;
        try_n   = '0;
        state_n = SQ_CLAIM;
      end
      SQ_CLAIM: begin
        if (own_ack) state_n = SQ_POLL;
        else begin
          stat_n  = XS_IO_ERR;
          state_n = SQ_RELEASE;
        end
      end
      SQ_POLL: begin
        if (chan_ready) state_n = SQ_LOAD;
        else if (poll_q == POLL_LAST) begin
          stat_n  = XS_BUSY;
          state_n = SQ_RELEASE;
        end else begin
          poll_n   = poll_q + PW'(1);
          tmr_load = 1'b1;
          tmr_val  = POLL_LD;
          state_n  = SQ_POLL_WAIT;
        end
      end
      SQ_POLL_WAIT: if (tmr_exp) state_n = SQ_POLL;
      SQ_LOAD: begin
        pay_load = ~cmd_q[0];
        state_n  = SQ_FIRE;
      end
      SQ_FIRE: state_n = SQ_PEND;
      SQ_PEND: if (!link_pending) begin
        tmr_load = 1'b1;
        tmr_val  = SETTLE_LD;
        state_n  = SQ_SETTLE;
      end
      SQ_SETTLE: if (tmr_exp) state_n = SQ_EVAL;
      SQ_EVAL: begin
        reply_n = link_reply;
        if (link_reply == RP_DEFER) begin
          if (try_q == TRY_LAST) begin
            stat_n  = XS_REMOTE_ERR;
            state_n = SQ_RELEASE;
          end else begin
            try_n   = try_q + RW'(1);
            state_n = SQ_FIRE;
          end
        end else if (cmd_q[0] && (link_rx_count != nb_q)) begin
          stat_n  = XS_REMOTE_ERR;
          state_n = SQ_RELEASE;
        end else begin
          rd_cap  = cmd_q[0];
          state_n = SQ_RELEASE;
        end
      end
      SQ_RELEASE: begin
        if (own_ack) stat_n = XS_IO_ERR;
        tmr_load = 1'b1;
        tmr_val  = GUARD_LD;
        state_n  = SQ_GUARD;
      end
      SQ_GUARD: if (tmr_exp) begin
        done_n  = 1'b1;
        state_n = SQ_IDLE;
      end
      default: state_n = SQ_IDLE;
    endcase
    // every exit path gives up ownership on entry to release
    if (state_n == SQ_RELEASE && state_q != SQ_RELEASE) own_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      nb_q    <= '0;
      poll_q  <= '0;
      try_q   <= '0;
      own_q   <= 1'b0;
      stat_q  <= XS_OK;
      reply_q <= RP_ACK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cmd_q   <= cmd_n;
      addr_q  <= addr_n;
      nb_q    <= nb_n;
      poll_q  <= poll_n;
      try_q   <= try_n;
      own_q   <= own_n;
      stat_q  <= stat_n;
      reply_q <= reply_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_cap) rd_data <= rx_masked;
  end

  assign busy        = (state_q != SQ_IDLE);
  assign done        = done_q;
  assign done_status = stat_q;
  assign done_reply  = reply_q;
  assign own_req     = own_q;
  assign link_trig   = (state_q == SQ_FIRE);
  assign link_cmd    = cmd_q;
  assign link_addr   = addr_q;
  assign link_len    = LEN_W'(nb_q - CNT_W'(1));
endmodule

// File: rtl/aux_xact_seq_chk.sv
module aux_xact_seq_chk #(
  parameter int MAX_TRIES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic own_req,
  input logic own_ack,
  input logic link_trig,
  input logic link_pending
);
  localparam int RW = $clog2(MAX_TRIES+1) + 1;
  logic [RW-1:0] trig_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         trig_seen <= '0;
    else if (!busy)     trig_seen <= '0;
    else if (link_trig) trig_seen <= trig_seen + RW'(1);
  end

  // R3: attempts only under acknowledged ownership
  assert_trig_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_trig |-> (own_req && own_ack));

  // R3: ownership is requested as soon as a request starts
  assert_claim_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> own_req);

  // R5: no attempt while one is still in flight, trigger lasts one cycle
  assert_trig_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_trig |-> !link_pending);
  assert_trig_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_trig |=> !link_trig);

  // R6: attempt count bounded
  assert_try_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_seen <= RW'(MAX_TRIES));

  // R8: ownership never held while idle
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !own_req);

  // R9: done is a lone pulse outside the busy window
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind aux_xact_seq aux_xact_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (.*);

// File: tb/aux_xact_seq_bench.sv
module aux_xact_seq_bench;
  localparam int US_T = 2, P_US = 5, S_US = 4, G_US = 6, TRIES = 16;
  localparam int SETTLE_C = S_US*US_T, GUARD_C = G_US*US_T, POLL_C = P_US*US_T;
  localparam int PEND_C = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic         req_valid;
  logic [3:0]   req_cmd;
  logic [19:0]  req_addr;
  logic [4:0]   req_nbytes;
  logic [127:0] req_wdata;
  logic         busy, done, own_req, own_ack, chan_ready, link_trig, link_pending;
  logic [1:0]   done_status, done_reply, link_reply;
  logic [127:0] rd_data, link_payload, link_rx_data;
  logic [3:0]   link_cmd, link_len;
  logic [19:0]  link_addr;
  logic [4:0]   link_rx_count;

  aux_xact_seq #(.US_TICKS(US_T), .POLL_US(P_US), .SETTLE_US(S_US),
                 .GUARD_US(G_US), .MAX_TRIES(TRIES)) u_aux_xact_seq (.*);

  // link and channel model
  logic ack_en, ack_stuck;
  int   pend_cnt, defer_left;
  logic [1:0] final_reply;
  logic [127:0] cap_payload;
  logic [3:0]   cap_cmd, cap_len;
  logic [19:0]  cap_addr;

  assign own_ack      = ack_en & (own_req | ack_stuck);
  assign link_pending = (pend_cnt != 0);

  always @(posedge clk) begin
    if (link_trig) begin
      pend_cnt    <= PEND_C;
      cap_payload <= link_payload;
      cap_cmd     <= link_cmd;
      cap_addr    <= link_addr;
      cap_len     <= link_len;
      if (defer_left > 0) begin
        link_reply <= 2'd2;
        defer_left <= defer_left - 1;
      end else link_reply <= final_reply;
    end else if (pend_cnt != 0) pend_cnt <= pend_cnt - 1;
  end

  int total = 0, bad = 0;
  int busy_c, rel_c, trig_c, gap_c, first_low, lows;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] c, input logic [19:0] a, input int nb,
                     input logic [127:0] wd);
    int cyc = 0;
    int last_low = -1;
    int timeout = 0;
    logic prev_pend = 1'b0;
    busy_c = 0; rel_c = 0; trig_c = 0; gap_c = -1;
    req_cmd = c; req_addr = a; req_nbytes = 5'(nb); req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (done) break;
      if (busy) busy_c++;
      if (busy && !own_req) rel_c++;
      if (!link_pending && prev_pend) last_low = cyc;
      if (link_trig) begin
        if (trig_c > 0) gap_c = cyc - last_low;
        trig_c++;
      end
      prev_pend = link_pending;
      cyc++;
      if (cyc > 20000) begin timeout = 1; break; end
      @(negedge clk);
    end
    if (timeout) begin
      total++; bad++;
      $display("FAIL watchdog: request never completed actual=busy expected=done");
    end
    // R9: done lasts a single cycle
    @(negedge clk);
    chk("R9 done one cycle", 128'(done), 128'(0));
    // R8: guard window after ownership is dropped
    chk("R8 guard window", 128'(rel_c), 128'(1 + GUARD_C));
  endtask

  function automatic logic [127:0] mask_bytes(input logic [127:0] d, input int n);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) if (i < n) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  localparam logic [127:0] W1 = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
  localparam logic [127:0] RX = 128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_nbytes = '0;
    req_wdata = '0; ack_en = 1'b1; ack_stuck = 1'b0; chan_ready = 1'b1;
    pend_cnt = 0; defer_left = 0; final_reply = 2'd0; link_reply = 2'd0;
    link_rx_count = '0; link_rx_data = RX;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 128'(busy), 0);
    chk("R1 done", 128'(done), 0);
    chk("R1 own_req", 128'(own_req), 0);
    chk("R1 link_trig", 128'(link_trig), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: native write of 4 bytes
    run(4'd8, 20'h00102, 4, W1);
    chk("R2 write status", 128'(done_status), 0);
    chk("R2 write payload", cap_payload, W1);
    chk("R2 write len", 128'(cap_len), 3);
    chk("R2 write cmd", 128'(cap_cmd), 8);
    chk("R2 write addr", 128'(cap_addr), 128'h00102);
    chk("R5 single trigger", 128'(trig_c), 1);

    // R2/R7: native read of 16 bytes, payload untouched
    link_rx_count = 5'd16;
    run(4'd9, 20'h00200, 16, ~W1);
    chk("R2 read keeps payload", cap_payload, W1);
    chk("R2 read len", 128'(cap_len), 15);
    chk("R7 read status", 128'(done_status), 0);
    chk("R7 read data", rd_data, RX);

    // R7: short read of 3 bytes
    link_rx_count = 5'd3;
    run(4'd9, 20'h00300, 3, '0);
    chk("R7 short read status", 128'(done_status), 0);
    chk("R7 short read data", rd_data, mask_bytes(RX, 3));

    // R7: count mismatch
    link_rx_count = 5'd2;
    run(4'd9, 20'h00300, 4, '0);
    chk("R7 mismatch status", 128'(done_status), 3);

    // R5/R6: three defers then ACK
    defer_left = 3;
    run(4'd8, 20'h00010, 1, W1);
    chk("R6 defer then ok status", 128'(done_status), 0);
    chk("R6 defer trigger count", 128'(trig_c), 4);
    chk("R5 retry spacing", 128'(gap_c), 128'(SETTLE_C + 2));

    // R6: defer exhaustion
    defer_left = 1000;
    run(4'd8, 20'h00010, 1, W1);
    chk("R6 exhausted status", 128'(done_status), 3);
    chk("R6 exhausted reply", 128'(done_reply), 2);
    chk("R6 exhausted triggers", 128'(trig_c), TRIES);
    defer_left = 0;

    // R9: NACK passes through with OK status
    final_reply = 2'd1;
    run(4'd8, 20'h00020, 2, W1);
    chk("R9 nack status", 128'(done_status), 0);
    chk("R9 nack reply", 128'(done_reply), 1);
    final_reply = 2'd0;

    // R3: ownership refused
    ack_en = 1'b0;
    run(4'd8, 20'h00030, 2, W1);
    chk("R3 refused status", 128'(done_status), 2);
    chk("R3 refused triggers", 128'(trig_c), 0);
    ack_en = 1'b1;

    // R4: never ready
    chan_ready = 1'b0;
    run(4'd9, 20'h00040, 1, '0);
    chk("R4 busy status", 128'(done_status), 1);
    chk("R4 busy triggers", 128'(trig_c), 0);
    chk("R4 poll timing", 128'(busy_c), 128'(5 + 2*POLL_C + GUARD_C));

    // R4: ready on second sample
    fork
      run(4'd8, 20'h00050, 1, W1);
      begin repeat (8) @(negedge clk); chan_ready = 1'b1; end
    join
    chk("R4 late ready status", 128'(done_status), 0);
    chk("R4 late ready triggers", 128'(trig_c), 1);

    // R8: acknowledge stuck after release
    ack_stuck = 1'b1;
    run(4'd8, 20'h00060, 1, W1);
    chk("R8 stuck ack status", 128'(done_status), 2);
    ack_stuck = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule